// File: doc/BRIEF.md
# Chip-Select Framed Serial Packet Receiver

This block receives a command packet of variable length on one asynchronous serial data line. A separate active-low chip-select input marks the start and the end of each packet. The serial line uses inverted polarity. It rests low, the start bit is high and each data bit is carried as its complement. Each character has 8 data bits, least significant bit first, with no parity. The receiver takes 16 samples per bit. It reads each bit near its centre, and the bit period comes from a system-clock divisor parameter. One bit period is 16 × `CLK_DIV` clock cycles. For 57600 baud on a 100 MHz clock, `CLK_DIV` is about 109.

The first byte of a packet is a length header. It counts itself, so a header of N means N bytes in total. The header goes to buffer slot 0, and the bytes after it go to slots 1 and up. Storage is limited to the buffer size, and excess bytes are dropped. A header of zero voids the packet. The receiver also drives a separate acknowledge line:
- It goes low when a packet starts.
- It goes high again once chip-select has returned high.

When a packet starts, the block also gives a one-cycle pulse that tells downstream logic to drop its address-ready flag. When chip-select rises after a complete packet, a one-cycle packet-valid pulse marks the buffer contents as ready.

Top module: `csf_pkt_rx`

## Requirements
- R1: While chip-select is high, serial traffic has no effect: the buffer, `pkt_len`, `ack_n` and `pkt_valid` are unchanged.
- R2: Within 4 clock cycles of chip-select falling, `ack_n` goes low and `rdy_clear` pulses high for exactly one cycle.
- R3: Line encoding: the line idles low and the start bit is high. Each of the 8 data bits is sent LSB first as the complement of its value (line low = 1), and the stop level is low. The bit period is 16 × `CLK_DIV` cycles, and each bit is sampled near its centre.
- R4: The first byte of a frame is the header. A nonzero header is stored in slot 0. `pkt_len` becomes min(header, `BUF_BYTES`).
- R5: After a nonzero header H, the next bytes are stored in arrival order into slots 1 up to min(H, `BUF_BYTES`) − 1.
- R6: With a header above `BUF_BYTES`, `pkt_len` = `BUF_BYTES`. Bytes past the last slot are discarded, and the slots already written keep their values.
- R7: When chip-select rises after all min(H, `BUF_BYTES`) bytes have arrived, `ack_n` returns high and `pkt_valid` pulses for exactly one cycle. This happens within 4 cycles of the rise.
- R8: When chip-select rises before the packet is complete, `ack_n` returns high and no `pkt_valid` pulse occurs.
- R9: A zero header voids the frame. The buffer and `pkt_len` stay unchanged and no `pkt_valid` pulse occurs.
- R10: After reset, `ack_n` = 1, `pkt_valid` = 0, `rdy_clear` = 0, `pkt_len` = 0 and every buffer byte is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low packet framing select |
| rx | input | 1 | Inverted-polarity serial data line |
| ack_n | output | 1 | Attention acknowledge, low while a frame is open |
| rdy_clear | output | 1 | One-cycle pulse at frame start to drop downstream address-ready |
| pkt_valid | output | 1 | One-cycle pulse when a complete packet has been framed |
| pkt_len | output | $clog2(BUF_BYTES+1) | Number of bytes the latest header asked to store, after clamping |
| buf_data | output | 8*BUF_BYTES | Buffer contents; slot i at bits [8i+7:8i] |

## Verification
The bench covers these corner cases:
- **Header of one.** The packet completes on the header alone. A design that waits for a second byte would never pulse `pkt_valid`.
- **Header of exactly the buffer size.** The packet fills every slot. An off-by-one store limit would lose slot 9 or write out of range.
- **Oversized header.** Overflow bytes would show up as a corrupted last slot or a wrong `pkt_len`.
- **Early chip-select rise.** A design that reports too soon would give a false `pkt_valid`.
- **Zero header.** A design that ignores the zero rule would write the header and the bytes after it into the buffer.
- **Traffic with chip-select high.** Bytes sent outside a frame should leave the buffer alone.
- **Bit patterns.** Data values 0x00, 0xFF, 0x01 and 0x80 show whether the polarity is inverted correctly and whether bits arrive LSB first.

// File: rtl/csf_pkg.sv
package csf_pkg;

  // Bytes a header asks to keep, limited to the buffer capacity.
  function automatic logic [7:0] clamp_count(input logic [7:0] hdr, input int cap);
    if (int'(hdr) > cap) return 8'(cap);
    return hdr;
  endfunction

  // Whether a byte at a given arrival position lands in the buffer.
  function automatic logic slot_open(input int pos, input int target);
    return (pos > 0) && (pos < target);
  endfunction

  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOPW} rx_state_t;

endpackage

// File: rtl/csf_sync.sv
module csf_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/csf_tick_gen.sv
module csf_tick_gen #(
  parameter int DIV = 109
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/csf_byte_rx.sv
module csf_byte_rx
  import csf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rx,
  output logic       done,
  output logic [7:0] data
);
  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] FULL = TW'(OSR - 1);

  rx_state_t     state;
  logic [TW-1:0] tcnt;
  logic [2:0]    bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_HUNT;
      tcnt  <= '0;
      bitn  <= '0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_HUNT;
        tcnt  <= '0;
      end else begin
        case (state)
          RX_HUNT: if (tick && rx) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tick) begin
            if (tcnt == MID) begin
              state <= rx ? RX_DATA : RX_HUNT;
              tcnt  <= '0;
              bitn  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            if (tcnt == FULL) begin
              tcnt <= '0;
              data <= {~rx, data[7:1]};
              if (bitn == 3'd7) begin
                done  <= 1'b1;
                state <= RX_STOPW;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_STOPW: if (!rx) state <= RX_HUNT;
          default: state <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/csf_frame_ctl.sv
module csf_frame_ctl
  import csf_pkg::*;
#(
  parameter int BUF_BYTES = 10,
  localparam int IDXW = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n_s,
  input  logic                   byte_done,
  input  logic [7:0]             byte_data,
  output logic                   cs_active,
  output logic                   wr_en,
  output logic [IDXW-1:0]        wr_idx,
  output logic                   ack_n,
  output logic                   rdy_clear,
  output logic                   pkt_valid,
  output logic [IDXW-1:0]        pkt_len,
  output logic [8*BUF_BYTES-1:0] buf_data
);
  logic            cs_q, in_frame, void_f;
  logic [IDXW-1:0] count, target;
  logic [7:0]      mem [BUF_BYTES];
  logic            cs_fall, cs_rise, is_hdr, complete;

  assign cs_fall   = cs_q & ~cs_n_s;
  assign cs_rise   = ~cs_q & cs_n_s;
  assign cs_active = in_frame & ~cs_n_s;
  assign is_hdr    = (count == '0);
  assign complete  = !is_hdr && (count == target);
  assign wr_idx    = count;
  assign wr_en     = cs_active && byte_done && !void_f &&
                     (is_hdr ? (byte_data != 8'd0)
                             : slot_open(int'(count), int'(target)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      in_frame  <= 1'b0;
      void_f    <= 1'b0;
      count     <= '0;
      target    <= '0;
      ack_n     <= 1'b1;
      rdy_clear <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      cs_q      <= cs_n_s;
      rdy_clear <= 1'b0;
      pkt_valid <= 1'b0;
      if (cs_fall) begin
        in_frame  <= 1'b1;
        void_f    <= 1'b0;
        count     <= '0;
        target    <= '0;
        ack_n     <= 1'b0;
        rdy_clear <= 1'b1;
      end else if (cs_rise && in_frame) begin
        in_frame  <= 1'b0;
        ack_n     <= 1'b1;
        pkt_valid <= complete && !void_f;
      end else if (cs_active && byte_done && !void_f) begin
        if (is_hdr) begin
          if (byte_data == 8'd0) begin
            void_f <= 1'b1;
          end else begin
            target  <= IDXW'(clamp_count(byte_data, BUF_BYTES));
            pkt_len <= IDXW'(clamp_count(byte_data, BUF_BYTES));
            count   <= IDXW'(1);
          end
        end else if (wr_en) begin
          count <= count + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en && (int'(wr_idx) == g))
        mem[g] <= byte_data;
    end
    assign buf_data[8*g +: 8] = mem[g];
  end
endmodule

// File: rtl/csf_pkt_rx.sv
module csf_pkt_rx #(
  parameter int CLK_DIV   = 109,
  parameter int OSR       = 16,
  parameter int BUF_BYTES = 10,
  localparam int IDXW = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rx,
  output logic                   ack_n,
  output logic                   rdy_clear,
  output logic                   pkt_valid,
  output logic [IDXW-1:0]        pkt_len,
  output logic [8*BUF_BYTES-1:0] buf_data
);
  logic [1:0]      sync_q;
  logic            cs_n_s, rx_s, tick;
  logic            cs_active, byte_done, wr_en;
  logic [7:0]      byte_data;
  logic [IDXW-1:0] wr_idx;

  csf_sync #(.W(2), .INIT(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rx}), .q(sync_q)
  );
  assign cs_n_s = sync_q[1];
  assign rx_s   = sync_q[0];

  csf_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  csf_byte_rx #(.OSR(OSR)) u_byte (
    .clk(clk), .rst_n(rst_n), .en(cs_active), .tick(tick), .rx(rx_s),
    .done(byte_done), .data(byte_data)
  );

  csf_frame_ctl #(.BUF_BYTES(BUF_BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s),
    .byte_done(byte_done), .byte_data(byte_data),
    .cs_active(cs_active), .wr_en(wr_en), .wr_idx(wr_idx),
    .ack_n(ack_n), .rdy_clear(rdy_clear), .pkt_valid(pkt_valid),
    .pkt_len(pkt_len), .buf_data(buf_data)
  );
endmodule

// File: rtl/csf_pkt_rx_chk.sv
module csf_pkt_rx_chk #(
  parameter int BUF_BYTES = 10,
  localparam int IDXW = $clog2(BUF_BYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_n,
  input logic            rdy_clear,
  input logic            pkt_valid,
  input logic [IDXW-1:0] pkt_len,
  input logic            byte_done,
  input logic            cs_active,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx
);
  // R1: a byte is only reported while a frame is open
  a_r1_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(cs_active));

  // R2: frame start drops the acknowledge line
  a_r2_clear_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_clear |-> !ack_n);

  // R2: the clear pulse is one cycle wide
  a_r2_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_clear |=> !rdy_clear);

  // R6: stores and length stay inside the buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < BUF_BYTES));

  a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pkt_len) <= BUF_BYTES);

  // R7: valid coincides with the acknowledge release and lasts one cycle
  a_r7_valid_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (ack_n && !$past(ack_n)));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);
endmodule

bind csf_pkt_rx csf_pkt_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .rdy_clear(rdy_clear),
  .pkt_valid(pkt_valid), .pkt_len(pkt_len), .byte_done(byte_done),
  .cs_active(cs_active), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/csf_pkt_rx_bench.sv
`timescale 1ns/1ps
module csf_pkt_rx_bench;
  localparam int DIV  = 2;
  localparam int BUFN = 10;
  localparam int BIT  = 16 * DIV;
  localparam int LW   = $clog2(BUFN + 1);

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx = 1'b0;
  logic ack_n, rdy_clear, pkt_valid;
  logic [LW-1:0] pkt_len;
  logic [8*BUFN-1:0] buf_data;

  int total = 0, bad = 0;
  int n_valid = 0, n_clear = 0;
  bit finished = 0;
  logic [7:0] exp_buf [BUFN];
  int exp_len = 0;

  always #5 clk = ~clk;

  csf_pkt_rx #(.CLK_DIV(DIV), .OSR(16), .BUF_BYTES(BUFN)) u_csf_pkt_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx(rx), .ack_n(ack_n),
    .rdy_clear(rdy_clear), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .buf_data(buf_data)
  );

  always @(negedge clk) begin
    if (pkt_valid) n_valid++;
    if (rdy_clear) n_clear++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R3: inverted line, start high, complemented data LSB first, stop low
  task automatic send_byte(input logic [7:0] b);
    rx = 1'b1; wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rx = ~b[i]; wait_cyc(BIT);
    end
    rx = 1'b0; wait_cyc(BIT + 4);
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < BUFN; i++)
      chk($sformatf("%s slot%0d", tag, i), int'(buf_data[8*i +: 8]), int'(exp_buf[i]));
    chk({tag, " pkt_len"}, int'(pkt_len), exp_len);
  endtask

  // Sends a framed packet; expected buffer updated from the requirements.
  task automatic frame(input string tag, input logic [7:0] bytes [], input bit exp_ok);
    int v0, c0, keep;
    v0 = n_valid; c0 = n_clear;
    cs_n = 1'b0; wait_cyc(4);
    chk({tag, " R2 ack low"}, int'(ack_n), 0);
    chk({tag, " R2 clear pulse"}, n_clear - c0, 1);
    foreach (bytes[k]) send_byte(bytes[k]);
    if (bytes.size() > 0 && bytes[0] != 8'd0) begin
      keep = (int'(bytes[0]) > BUFN) ? BUFN : int'(bytes[0]);
      exp_len = keep;
      for (int k = 0; k < keep && k < bytes.size(); k++) exp_buf[k] = bytes[k];
    end
    chk({tag, " R1 ack held low"}, int'(ack_n), 0);
    cs_n = 1'b1; wait_cyc(4);
    chk({tag, " R7 ack high"}, int'(ack_n), 1);
    chk({tag, exp_ok ? " R7 valid once" : " R8 no valid"}, n_valid - v0, exp_ok ? 1 : 0);
    wait_cyc(10);
    check_state(tag);
  endtask

  task automatic t_reset;
    for (int i = 0; i < BUFN; i++) exp_buf[i] = 8'h00;
    chk("R10 ack_n", int'(ack_n), 1);
    chk("R10 pkt_valid", int'(pkt_valid), 0);
    chk("R10 rdy_clear", int'(rdy_clear), 0);
    check_state("R10");
  endtask

  task automatic t_cs_high;
    int v0, c0;
    v0 = n_valid; c0 = n_clear;
    send_byte(8'h03); send_byte(8'h11); send_byte(8'h22);
    chk("R1 ack stays high", int'(ack_n), 1);
    chk("R1 no valid", n_valid - v0, 0);
    chk("R1 no clear", n_clear - c0, 0);
    check_state("R1 idle");
  endtask

  task automatic t_basic;
    frame("R4 R5 basic", '{8'h04, 8'hA5, 8'h3C, 8'h81}, 1'b1);
  endtask

  task automatic t_hdr_one;
    frame("R4 hdr1", '{8'h01}, 1'b1);
  endtask

  task automatic t_full;
    frame("R5 R3 full", '{8'h0A, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hC3, 8'h7E, 8'h96, 8'h69}, 1'b1);
  endtask

  task automatic t_overflow;
    frame("R6 over", '{8'h0E, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70,
                       8'h90, 8'hA9, 8'hEE, 8'hDD, 8'hCC, 8'hBB}, 1'b1);
  endtask

  task automatic t_short;
    frame("R8 short", '{8'h05, 8'h12, 8'h34}, 1'b0);
  endtask

  task automatic t_zero;
    frame("R9 zero", '{8'h00, 8'h55, 8'h66}, 1'b0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_cs_high();
    t_basic();
    t_hdr_one();
    t_full();
    t_overflow();
    t_short();
    t_zero();
    t_basic();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule